// File: doc/BRIEF.md
# Quadword System Data Bus Controller

This block is the data-path half of a processor's external system data bus. The bus is 128 bits wide and carries 16 check bits with it. Each 64-bit half has its own 8 check bits from a (72,64) single-error-correcting, double-error-detecting code. A transfer is either a 64-byte block, moved as four quadword beats, or a single noncached quadword qualified by a 16-bit byte mask. The system starts the data phase with a reply strobe. During block transfers it can hold the next beat back with a stall input.

Outgoing data comes from a valid/ready stream. `wr_ready_o` is high only while a write transfer is active and is not stalled, and a beat goes onto the bus only in a cycle where `wr_valid_i` and `wr_ready_o` are both high. If the source has no data, the beat simply waits. Incoming data is delivered as a valid-only stream one cycle after the beat is taken from the bus. The bus cannot be held once data is sampled, so the consumer must accept every `rd_valid_o` beat. The delivered beat comes with corrected data, its byte mask, its beat index and per-half error flags. Control and status pins are plain levels or one-cycle pulses.

Top module: `sdb_quad_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `bus_drive_o`, `wr_ready_o`, `rd_valid_o` and `proto_err_o` are low.
- R2: A reply strobe while idle latches the transfer kind (block/single, write/read) and the mask. `busy_o` is high from the next cycle, with `beat_o` = 0. For a block the latched mask is all ones, whatever is on `reply_mask_i`.
- R3: A block moves four beats in ascending order 0,1,2,3. `done_o` is high in the cycle the beat 3 transfer completes, and `busy_o` is low in the cycle after.
- R4: During a block, while `stall_i` is high no beat completes. `beat_o` holds, `wr_ready_o` and `bus_drive_o` are low, and no read beat is delivered.
- R5: A single transfer moves exactly one beat, with `done_o` high in that cycle. `stall_i` has no effect on it.
- R6: A write beat completes only when `wr_valid_i` and `wr_ready_o` are both high. `bus_drive_o` marks that cycle. If `wr_valid_i` is low, the beat waits.
- R7: On writes, byte k of `bus_dout_o` (bits 8k+7:8k) equals that byte of `wr_data_i` when mask bit k is set, and is zero otherwise. `bus_cout_o[7:0]` protects `bus_dout_o[63:0]` and `bus_cout_o[15:8]` protects `bus_dout_o[127:64]`. Each is computed over the masked half. Check bit j of a half is the XOR of the data bits i whose column has bit j set. Column i is the i-th smallest (from 0) 8-bit value of odd weight 3 or more.
- R8: Each read beat taken from the bus produces `rd_valid_o` one cycle later. It carries that beat's `rd_beat_o` and the latched mask on `rd_mask_o`.
- R9: If a half's syndrome (regenerated check bits XOR received check bits) equals a data column, that data bit is corrected. If the syndrome has exactly one bit set, it is a check-bit error and the data is left unchanged. In both cases that half's bit of `rd_ce_o` is set (bit 0 = low half, bit 1 = high half).
- R10: Any other nonzero syndrome, such as any two-bit error, sets that half's bit of `rd_ue_o` and leaves that half's data unmodified. `rd_ce_o` and `rd_ue_o` are never both set for one half.
- R11: A zero syndrome delivers the data unchanged with no flags.
- R12: A reply strobe while busy is ignored: the transfer in progress keeps its kind, mask and beat. `proto_err_o` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reply_i | input | 1 | System reply strobe that starts a data phase |
| reply_block_i | input | 1 | 1 = 64-byte block, 0 = single quadword |
| reply_write_i | input | 1 | 1 = write (send to bus), 0 = read |
| reply_mask_i | input | 16 | Byte mask for single transfers |
| stall_i | input | 1 | System cannot move a block beat this cycle |
| wr_valid_i | input | 1 | Outgoing beat data valid |
| wr_ready_o | output | 1 | Block accepts outgoing beat |
| wr_data_i | input | 128 | Outgoing beat data |
| bus_dout_o | output | 128 | Masked data toward the bus |
| bus_cout_o | output | 16 | Check bits toward the bus |
| bus_drive_o | output | 1 | Write beat placed on the bus this cycle |
| bus_din_i | input | 128 | Data from the bus |
| bus_cin_i | input | 16 | Check bits from the bus |
| rd_valid_o | output | 1 | Delivered read beat valid |
| rd_data_o | output | 128 | Corrected read data |
| rd_mask_o | output | 16 | Byte mask of the delivered beat |
| rd_beat_o | output | 2 | Beat index of the delivered beat |
| rd_ce_o | output | 2 | Per-half corrected-error flags |
| rd_ue_o | output | 2 | Per-half uncorrectable-error flags |
| busy_o | output | 1 | Transfer in progress |
| beat_o | output | 2 | Current beat index |
| done_o | output | 1 | Last beat of a transfer completes this cycle |
| proto_err_o | output | 1 | Reply strobe arrived while busy |

## Verification
The decoder is driven with a table of received beats. Each has a chosen set of flipped data and check bits: clean data, a single data-bit flip in either half and in both halves, a single check-bit flip, two flips in one half with or without a single flip in the other, and one data flip paired with one check flip. Together these separate true correction from check-bit-only errors, keep the two halves independent, and show that uncorrectable data stays unmodified. Block reads and writes are run with stall cycles and with a missing write source to show that beats hold and keep their order. A strobe is injected mid-block to show it is ignored. A single write with a sparse mask shows lane zeroing and the check bits computed over the zeroed lanes.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  localparam int LANE_W_DEF = 64;
  localparam int CHK_W_DEF  = 8;
  localparam int LANES_DEF  = 2;
  localparam int BEATS_DEF  = 4;

  // Column k of the code matrix: the k-th smallest value of cw bits whose
  // weight is odd and at least three (weight-one columns are the check bits).
  function automatic int code_col(int k, int cw);
    int seen;
    int res;
    int w;
    seen = 0;
    res  = 0;
    for (int v = 0; v < (1 << cw); v++) begin
      w = 0;
      for (int b = 0; b < cw; b++) w += (v >> b) & 1;
      if (w >= 3 && (w % 2) == 1) begin
        if (seen == k) res = v;
        seen++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/sdb_chk_gen.sv
module sdb_chk_gen #(
  parameter int DATA_W = sdb_pkg::LANE_W_DEF,
  parameter int CHK_W  = sdb_pkg::CHK_W_DEF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [CHK_W-1:0] term [DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = CHK_W'(sdb_pkg::code_col(i, CHK_W));
    assign term[i] = data_i[i] ? COL : '0;
  end

  always_comb begin
    chk_o = '0;
    for (int i = 0; i < DATA_W; i++) chk_o = chk_o ^ term[i];
  end

endmodule

// File: rtl/sdb_chk_fix.sv
module sdb_chk_fix #(
  parameter int DATA_W = sdb_pkg::LANE_W_DEF,
  parameter int CHK_W  = sdb_pkg::CHK_W_DEF
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ce_o,
  output logic              ue_o
);

  logic [CHK_W-1:0]  regen;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] hit;

  sdb_chk_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_regen (
    .data_i (data_i),
    .chk_o  (regen)
  );

  assign syn = regen ^ chk_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_match
    localparam logic [CHK_W-1:0] COL = CHK_W'(sdb_pkg::code_col(i, CHK_W));
    assign hit[i] = (syn == COL);
  end

  // Only a syndrome equal to a data column flips a bit; otherwise hit is zero.
  assign data_o = data_i ^ hit;
  assign ce_o   = (syn != '0) && ((|hit) || $onehot(syn));
  assign ue_o   = (syn != '0) && !ce_o;

endmodule

// File: rtl/sdb_beat_seq.sv
module sdb_beat_seq #(
  parameter int BEATS   = sdb_pkg::BEATS_DEF,
  parameter int MASK_W  = 16,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reply_i,
  input  logic              blk_i,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              stall_i,
  input  logic              wr_valid_i,
  output logic              busy_o,
  output logic              blk_o,
  output logic              wr_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              fire_o,
  output logic              done_o,
  output logic              proto_err_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              busy_q;
  logic              blk_q;
  logic              wr_q;
  logic [MASK_W-1:0] mask_q;
  logic [BEAT_W-1:0] beat_q;
  logic              held;
  logic              last;

  assign held        = blk_q && stall_i;
  assign fire_o      = busy_q && !held && (!wr_q || wr_valid_i);
  assign last        = !blk_q || (beat_q == LAST_BEAT);
  assign done_o      = fire_o && last;
  assign proto_err_o = reply_i && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      blk_q  <= 1'b0;
      wr_q   <= 1'b0;
      mask_q <= '0;
      beat_q <= '0;
    end else if (!busy_q) begin
      if (reply_i) begin
        busy_q <= 1'b1;
        blk_q  <= blk_i;
        wr_q   <= wr_i;
        mask_q <= blk_i ? '1 : mask_i;
        beat_q <= '0;
      end
    end else if (fire_o) begin
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign blk_o  = blk_q;
  assign wr_o   = wr_q;
  assign mask_o = mask_q;
  assign beat_o = beat_q;

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && blk_q && stall_i) |=> (busy_q && $stable(beat_q)));

  a_r3_beat_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !last) |=> (beat_q == $past(beat_q) + 1'b1));

  a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);

  a_r12_reply_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_i && busy_q && !fire_o) |=>
      (busy_q && $stable(mask_q) && $stable(beat_q) && $stable(blk_q) && $stable(wr_q)));

endmodule

// File: rtl/sdb_quad_ctrl.sv
module sdb_quad_ctrl #(
  parameter int LANE_W  = sdb_pkg::LANE_W_DEF,
  parameter int CHK_W   = sdb_pkg::CHK_W_DEF,
  parameter int LANES   = sdb_pkg::LANES_DEF,
  parameter int BEATS   = sdb_pkg::BEATS_DEF,
  localparam int DATA_W = LANE_W * LANES,
  localparam int BYTES  = DATA_W / 8,
  localparam int CBUS_W = CHK_W * LANES,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reply_i,
  input  logic              reply_block_i,
  input  logic              reply_write_i,
  input  logic [BYTES-1:0]  reply_mask_i,
  input  logic              stall_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic [CBUS_W-1:0] bus_cout_o,
  output logic              bus_drive_o,
  input  logic [DATA_W-1:0] bus_din_i,
  input  logic [CBUS_W-1:0] bus_cin_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [BYTES-1:0]  rd_mask_o,
  output logic [BEAT_W-1:0] rd_beat_o,
  output logic [LANES-1:0]  rd_ce_o,
  output logic [LANES-1:0]  rd_ue_o,
  output logic              busy_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              done_o,
  output logic              proto_err_o
);

  logic              busy;
  logic              blk;
  logic              wr;
  logic [BYTES-1:0]  mask;
  logic [BEAT_W-1:0] beat;
  logic              fire;
  logic              rd_fire;
  logic [DATA_W-1:0] lane_keep;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] fixed;
  logic [LANES-1:0]  ce;
  logic [LANES-1:0]  ue;

  sdb_beat_seq #(.BEATS(BEATS), .MASK_W(BYTES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .reply_i     (reply_i),
    .blk_i       (reply_block_i),
    .wr_i        (reply_write_i),
    .mask_i      (reply_mask_i),
    .stall_i     (stall_i),
    .wr_valid_i  (wr_valid_i),
    .busy_o      (busy),
    .blk_o       (blk),
    .wr_o        (wr),
    .mask_o      (mask),
    .beat_o      (beat),
    .fire_o      (fire),
    .done_o      (done_o),
    .proto_err_o (proto_err_o)
  );

  // Byte-lane qualification of outgoing data.
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign lane_keep[8*b +: 8] = {8{mask[b]}};
  end
  assign masked = wr_data_i & lane_keep;

  // One independent code lane per half of the bus.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sdb_chk_gen #(.DATA_W(LANE_W), .CHK_W(CHK_W)) u_gen (
      .data_i (masked[LANE_W*l +: LANE_W]),
      .chk_o  (bus_cout_o[CHK_W*l +: CHK_W])
    );
    sdb_chk_fix #(.DATA_W(LANE_W), .CHK_W(CHK_W)) u_fix (
      .data_i (bus_din_i[LANE_W*l +: LANE_W]),
      .chk_i  (bus_cin_i[CHK_W*l +: CHK_W]),
      .data_o (fixed[LANE_W*l +: LANE_W]),
      .ce_o   (ce[l]),
      .ue_o   (ue[l])
    );
  end

  assign bus_dout_o  = masked;
  assign wr_ready_o  = busy && wr && !(blk && stall_i);
  assign bus_drive_o = fire && wr;
  assign rd_fire     = fire && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_mask_o  <= '0;
      rd_beat_o  <= '0;
      rd_ce_o    <= '0;
      rd_ue_o    <= '0;
    end else begin
      rd_valid_o <= rd_fire;
      if (rd_fire) begin
        rd_data_o <= fixed;
        rd_mask_o <= mask;
        rd_beat_o <= beat;
        rd_ce_o   <= ce;
        rd_ue_o   <= ue;
      end
    end
  end

  assign busy_o = busy;
  assign beat_o = beat;

  a_r6_drive_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> (wr_valid_i && wr_ready_o));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> ((rd_ce_o & rd_ue_o) == '0));

  a_r4_no_read_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && blk && !wr && stall_i) |=> !rd_valid_o);

  a_r5_single_ignores_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk && !wr) |=> (rd_valid_o && !busy));

endmodule

// File: tb/test_sdb_quad_ctrl.sv
module test_sdb_quad_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reply_i = 1'b0;
  logic         reply_block_i = 1'b0;
  logic         reply_write_i = 1'b0;
  logic [15:0]  reply_mask_i = '0;
  logic         stall_i = 1'b0;
  logic         wr_valid_i = 1'b0;
  logic         wr_ready_o;
  logic [127:0] wr_data_i = '0;
  logic [127:0] bus_dout_o;
  logic [15:0]  bus_cout_o;
  logic         bus_drive_o;
  logic [127:0] bus_din_i = '0;
  logic [15:0]  bus_cin_i = '0;
  logic         rd_valid_o;
  logic [127:0] rd_data_o;
  logic [15:0]  rd_mask_o;
  logic [1:0]   rd_beat_o;
  logic [1:0]   rd_ce_o;
  logic [1:0]   rd_ue_o;
  logic         busy_o;
  logic [1:0]   beat_o;
  logic         done_o;
  logic         proto_err_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sdb_quad_ctrl i_sdb_quad_ctrl (.*);

  typedef struct packed {
    logic [127:0] d;
    logic [127:0] dflip;
    logic [15:0]  cflip;
    logic [1:0]   ce;
    logic [1:0]   ue;
  } vec_t;

  localparam logic [127:0] PAT = 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;
  localparam logic [127:0] ONE = 128'd1;

  localparam vec_t TAB [9] = '{
    '{PAT,        '0,                         16'h0000, 2'b00, 2'b00},
    '{PAT,        ONE << 5,                   16'h0000, 2'b01, 2'b00},
    '{~PAT,       ONE << 100,                 16'h0000, 2'b10, 2'b00},
    '{PAT ^ 128'hFF, (ONE << 0) | (ONE << 127), 16'h0000, 2'b11, 2'b00},
    '{PAT,        '0,                         16'h0008, 2'b01, 2'b00},
    '{PAT,        (ONE << 70) | (ONE << 71),  16'h0000, 2'b00, 2'b10},
    '{~PAT,       (ONE << 1) | (ONE << 2) | (ONE << 64), 16'h0000, 2'b10, 2'b01},
    '{PAT,        '0,                         16'h0300, 2'b00, 2'b10},
    '{PAT,        ONE << 10,                  16'h0001, 2'b00, 2'b01}
  };

  // Code columns as the requirement defines them (R7).
  function automatic logic [7:0] tb_col(int k);
    int seen = 0;
    logic [7:0] r = '0;
    for (int v = 0; v < 256; v++) begin
      int w = $countones(v[7:0]);
      if (w >= 3 && (w % 2) == 1) begin
        if (seen == k) r = v[7:0];
        seen++;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] tb_chk(logic [63:0] d);
    logic [7:0] r = '0;
    for (int i = 0; i < 64; i++) if (d[i]) r = r ^ tb_col(i);
    return r;
  endfunction

  function automatic logic [15:0] tb_chk2(logic [127:0] d);
    return {tb_chk(d[127:64]), tb_chk(d[63:0])};
  endfunction

  function automatic logic [127:0] tb_mask(logic [127:0] d, logic [15:0] m);
    logic [127:0] r = d;
    for (int b = 0; b < 16; b++) if (!m[b]) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pulse the reply strobe for one cycle; returns at the negedge after latching.
  task automatic start(logic blk, logic wr, logic [15:0] m);
    @(negedge clk);
    reply_i = 1'b1; reply_block_i = blk; reply_write_i = wr; reply_mask_i = m;
    @(negedge clk);
    reply_i = 1'b0; reply_mask_i = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [127:0] d;
    logic [127:0] exp_d;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", 128'(busy_o), 0);
    chk("R1 outputs", 128'({done_o, bus_drive_o, wr_ready_o, rd_valid_o, proto_err_o}), 0);
    rst_n = 1'b1;

    // Table of single reads through the decoder (R9 R10 R11, R5, R8)
    for (int t = 0; t < 9; t++) begin
      start(1'b0, 1'b0, 16'hFFFF);
      chk("R2 busy after strobe", 128'({busy_o, beat_o}), 128'({1'b1, 2'd0}));
      bus_din_i = TAB[t].d ^ TAB[t].dflip;
      bus_cin_i = tb_chk2(TAB[t].d) ^ TAB[t].cflip;
      stall_i = (t % 2) == 1;              // R5: stall has no effect on singles
      #1 chk("R5 single done", 128'(done_o), 1);
      @(negedge clk);
      stall_i = 1'b0;
      exp_d[63:0]   = TAB[t].ue[0] ? bus_din_i[63:0]   : TAB[t].d[63:0];
      exp_d[127:64] = TAB[t].ue[1] ? bus_din_i[127:64] : TAB[t].d[127:64];
      chk("R8 rd_valid", 128'(rd_valid_o), 1);
      chk(TAB[t].ue != 0 ? "R10 data kept" : (TAB[t].ce != 0 ? "R9 data fixed" : "R11 clean data"),
          rd_data_o, exp_d);
      chk("R9 ce flags", 128'(rd_ce_o), 128'(TAB[t].ce));
      chk("R10 ue flags", 128'(rd_ue_o), 128'(TAB[t].ue));
      chk("R5 idle after single", 128'(busy_o), 0);
    end

    // Block read with stalls and a stray strobe (R2 R3 R4 R8 R12)
    start(1'b1, 1'b0, 16'h0001);
    for (int k = 0; k < 4; k++) begin
      if (k == 1 || k == 3) begin
        for (int s = 0; s < (k == 3 ? 2 : 1); s++) begin
          stall_i = 1'b1;
          bus_din_i = '1; bus_cin_i = '0;
          #1 chk("R4 no done in stall", 128'(done_o), 0);
          @(negedge clk);
          chk("R4 no read in stall", 128'(rd_valid_o), 0);
          chk("R4 beat holds", 128'(beat_o), 128'(k));
        end
      end
      stall_i = 1'b0;
      d = PAT ^ {32{4'(k)}};
      bus_din_i = d; bus_cin_i = tb_chk2(d);
      if (k == 1) begin
        reply_i = 1'b1; reply_block_i = 1'b0; reply_write_i = 1'b1; reply_mask_i = 16'h0003;
      end
      #1;
      if (k == 1) chk("R12 proto err", 128'(proto_err_o), 1);
      chk("R3 done only on last", 128'(done_o), 128'(k == 3));
      @(negedge clk);
      reply_i = 1'b0; reply_mask_i = '0;
      chk("R8 rd beat", 128'({rd_valid_o, rd_beat_o}), 128'({1'b1, 2'(k)}));
      chk("R3 block data", rd_data_o, d);
      chk("R12 mask kept", 128'(rd_mask_o), 128'hFFFF);
    end
    chk("R3 idle after block", 128'(busy_o), 0);
    @(negedge clk);
    chk("R12 strobe did not start", 128'(busy_o), 0);

    // Single write with sparse mask (R6 R7 R5)
    start(1'b0, 1'b1, 16'h0F3C);
    wr_valid_i = 1'b0;
    #1 chk("R6 ready without data", 128'({wr_ready_o, bus_drive_o}), 128'(2'b10));
    @(negedge clk);
    chk("R6 waits for data", 128'(busy_o), 1);
    wr_valid_i = 1'b1; wr_data_i = ~PAT; stall_i = 1'b1;
    #1;
    chk("R5 stall ignored on single", 128'({wr_ready_o, bus_drive_o, done_o}), 128'(3'b111));
    chk("R7 masked data", bus_dout_o, tb_mask(~PAT, 16'h0F3C));
    chk("R7 check bits", 128'(bus_cout_o), 128'(tb_chk2(tb_mask(~PAT, 16'h0F3C))));
    @(negedge clk);
    wr_valid_i = 1'b0; stall_i = 1'b0;
    chk("R5 idle after write", 128'(busy_o), 0);

    // Block write with a stall (R3 R4 R6 R7)
    start(1'b1, 1'b1, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      d = {4{32'(k * 32'h1111_0001 + 32'h5A5A_0000)}};
      wr_valid_i = 1'b1; wr_data_i = d;
      if (k == 2) begin
        stall_i = 1'b1;
        #1 chk("R4 write held", 128'({wr_ready_o, bus_drive_o}), 0);
        @(negedge clk);
        chk("R4 beat holds on write", 128'(beat_o), 2);
        stall_i = 1'b0;
      end
      #1;
      chk("R6 block drive", 128'({bus_drive_o, beat_o}), 128'({1'b1, 2'(k)}));
      chk("R7 block data", bus_dout_o, d);
      chk("R7 block check", 128'(bus_cout_o), 128'(tb_chk2(d)));
      chk("R3 write done", 128'(done_o), 128'(k == 3));
      @(negedge clk);
    end
    wr_valid_i = 1'b0;
    chk("R3 idle after write block", 128'(busy_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule